// File: doc/BRIEF.md
# Dual-View Framebuffer Access Front End

This block sits between a host register-style bus and a packed 8-bit-per-pixel framebuffer store for a 1152 x 900 display. The host sees the same pixels through two windows. In the plane window, each 16-bit word carries one bit of one plane for 16 neighbouring pixels. In the pixel window, each byte address is one whole pixel. A plane-enable mask register gates which planes a host access may read or change.

The store holds whole pixels, so a plane-window word access is broken into 16 read-modify-write steps on the store. Reads collect one bit per pixel. Writes replace only the selected plane bit in each pixel. Pixel-window writes also use read-modify-write, which lets them respect the mask. The store is external and has one cycle of read latency. The host holds a request until `ready_o` pulses for one cycle.

Top module: `fb_dual_view`

## Requirements
- R1: After reset `ready_o`, `st_re_o` and `st_we_o` are low, and the plane mask is 0xFF (all planes enabled). A later reset restores 0xFF.
- R2: Address map on the 22-bit byte address. 0x000000-0x0FFFFF is the plane window. 0x100000-0x1FFFFF is the pixel window. 0x200000 is the mask register, held in bits [7:0] and read back with bits [15:8] zero. Any other address reads zero and ignores writes.
- R3: In the plane window, plane p occupies byte offsets p*0x20000 to p*0x20000+0x1FFFF. The word at byte offset 2w within that range covers pixels 16w to 16w+15. Bit 15 is pixel 16w and bit 0 is pixel 16w+15. Each bit is bit p of that pixel byte.
- R4: A plane-window write changes only bit p of the 16 covered pixels. All other bits of those pixels are kept.
- R5: A plane-window read returns bit p of each of the 16 covered pixels, in the order given by R3.
- R6: When mask bit p is clear, a plane-window write to plane p changes nothing and a read returns 0. Neither performs any store access.
- R7: A pixel-window write replaces only the pixel bits whose mask bit is set. A pixel-window read returns the stored byte ANDed with the mask, in `rdata_o[7:0]`, with bits [15:8] zero.
- R8: An access to a pixel index of 1152*900 = 1036800 or more reads zero, ignores the write and makes no store access. In the plane window this means word index 64800 or above.
- R9: `ready_o` is high for exactly one cycle per request. Counting the accepting clock edge as the first, it rises after 33 edges for a plane-window access that touches the store, after 3 edges for a pixel-window access that touches the store, and after 1 edge otherwise.
- R10: Every store write is made in the cycle right after a store read of the same address. A plane-window write makes 16 reads and 16 writes. A plane-window read makes 16 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host request, held until ready |
| we_i | input | 1 | Host write (1) or read (0) |
| addr_i | input | 22 | Host byte address |
| wdata_i | input | 16 | Host write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with ready_o |
| st_addr_o | output | 20 | Pixel store address (pixel index) |
| st_re_o | output | 1 | Pixel store read strobe |
| st_we_o | output | 1 | Pixel store write strobe |
| st_wdata_o | output | 8 | Pixel store write data |
| st_rdata_i | input | 8 | Pixel store read data, one cycle after st_re_o |

## Verification
Some properties are checked by assertions on every cycle. These are: ready is a single-cycle pulse; every store write follows a read of the same address; a plane-window write flips at most one bit per pixel and a pixel-window write changes no masked-off bit; the store address never leaves the visible area; and the mask holds its value unless it is written. Other behaviour can only be shown by the bench's scenarios. This covers the bit order within a word, how the two windows alias onto one pixel, what a disabled plane or the mask does to read data, the boundary at the last visible pixel, and the exact latency and store access counts for each kind of access.

// File: rtl/fbv_pkg.sv
package fbv_pkg;
  typedef enum logic [1:0] {K_NONE, K_PLANE, K_PIXEL, K_MASK} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_RD, S_MOD, S_DONE} state_e;
endpackage

// File: rtl/fbv_decode.sv
module fbv_decode
  import fbv_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int VIEW_AW = 20,
  parameter int PLANES  = 8,
  parameter int BUS_W   = 16,
  parameter int NPIX    = 1036800,
  parameter int SA_W    = 20
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [PLANES-1:0]         mask_i,
  output kind_e                     kind_o,
  output logic [$clog2(PLANES)-1:0] plane_o,
  output logic [SA_W-1:0]           base_o,
  output logic                      go_o
);
  localparam int PL_W   = $clog2(PLANES);
  localparam int REG_AW = VIEW_AW - PL_W;
  localparam int BYTE_W = $clog2(BUS_W / 8);
  localparam int WORD_W = REG_AW - BYTE_W;
  localparam int GRP_W  = $clog2(BUS_W);
  localparam int RG_W   = ADDR_W - VIEW_AW;

  logic [RG_W-1:0]   region;
  logic [WORD_W-1:0] word_idx;
  logic [31:0]       base_wide;
  logic              in_range;

  assign region   = addr_i[ADDR_W-1:VIEW_AW];
  assign plane_o  = addr_i[VIEW_AW-1 -: PL_W];
  assign word_idx = addr_i[REG_AW-1:BYTE_W];

  always_comb begin
    kind_o    = K_NONE;
    base_wide = '0;
    if (region == RG_W'(0)) begin
      kind_o    = K_PLANE;
      base_wide = 32'(word_idx) << GRP_W;  // word w -> first pixel 16w
    end else if (region == RG_W'(1)) begin
      kind_o    = K_PIXEL;
      base_wide = 32'(addr_i[VIEW_AW-1:0]);
    end else if (region == RG_W'(2) && addr_i[VIEW_AW-1:0] == '0) begin
      kind_o = K_MASK;
    end
  end

  assign in_range = base_wide < 32'(NPIX);
  assign base_o   = SA_W'(base_wide);
  assign go_o     = in_range &&
                    ((kind_o == K_PIXEL) || (kind_o == K_PLANE && mask_i[plane_o]));
endmodule

// File: rtl/fbv_mask_reg.sv
module fbv_mask_reg #(
  parameter int PLANES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PLANES-1:0] wdata_i,
  output logic [PLANES-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '1;
    else if (we_i) mask_o <= wdata_i;
  end

  // R2
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/fbv_seq.sv
module fbv_seq
  import fbv_pkg::*;
#(
  parameter int PLANES = 8,
  parameter int BUS_W  = 16,
  parameter int SA_W   = 20,
  parameter int PL_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  kind_e             kind_i,
  input  logic [PL_W-1:0]   plane_i,
  input  logic [SA_W-1:0]   base_i,
  input  logic              go_i,
  input  logic [PLANES-1:0] mask_i,
  output logic              mask_we_o,
  output logic              ready_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [SA_W-1:0]   st_addr_o,
  output logic              st_re_o,
  output logic              st_we_o,
  output logic [PLANES-1:0] st_wdata_o,
  input  logic [PLANES-1:0] st_rdata_i
);
  localparam int CNT_W = $clog2(BUS_W);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BUS_W - 1);

  state_e             state_q;
  kind_e              kind_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SA_W-1:0]    base_q;
  logic [PL_W-1:0]    plane_q;
  logic               we_q;
  logic [BUS_W-1:0]   wdata_q;
  logic [BUS_W-1:0]   acc_q;
  logic [CNT_W-1:0]   bit_idx;

  assign bit_idx   = LAST_C - cnt_q;  // bit 15 is leftmost pixel
  assign mask_we_o = (state_q == S_IDLE) && req_i && we_i && (kind_i == K_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_NONE;
      cnt_q   <= '0;
      base_q  <= '0;
      plane_q <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      acc_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_i) begin
          kind_q  <= kind_i;
          base_q  <= base_i;
          plane_q <= plane_i;
          we_q    <= we_i;
          wdata_q <= wdata_i;
          cnt_q   <= '0;
          acc_q   <= (kind_i == K_MASK && !we_i) ? BUS_W'(mask_i) : '0;
          state_q <= go_i ? S_RD : S_DONE;
        end
        S_RD: state_q <= S_MOD;
        S_MOD: begin
          if (!we_q) begin
            if (kind_q == K_PLANE) acc_q[bit_idx] <= st_rdata_i[plane_q];
            else                   acc_q <= BUS_W'(st_rdata_i & mask_i);
          end
          if (kind_q == K_PLANE && cnt_q != LAST_C) begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= S_RD;
          end else begin
            state_q <= S_DONE;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st_wdata_o = st_rdata_i;
    if (kind_q == K_PLANE) st_wdata_o[plane_q] = wdata_q[bit_idx];
    else st_wdata_o = (st_rdata_i & ~mask_i) | (wdata_q[PLANES-1:0] & mask_i);
  end

  assign st_addr_o = base_q + SA_W'(cnt_q);
  assign st_re_o   = (state_q == S_RD);
  assign st_we_o   = (state_q == S_MOD) && we_q;
  assign ready_o   = (state_q == S_DONE);
  assign rdata_o   = acc_q;

  // R9
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  // R10
  rmw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we_o |-> ($past(st_re_o) && st_addr_o == $past(st_addr_o)));
  // R4
  plane_one_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_o && kind_q == K_PLANE) |-> ($countones(st_wdata_o ^ st_rdata_i) <= 1));
  // R7
  pixel_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_o && kind_q == K_PIXEL) |-> (((st_wdata_o ^ st_rdata_i) & ~mask_i) == '0));
  // R9
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && kind_q != K_PLANE) |-> (cnt_q == '0));
endmodule

// File: rtl/fb_dual_view.sv
module fb_dual_view
  import fbv_pkg::*;
#(
  parameter int H_PIX   = 1152,
  parameter int V_LINES = 900,
  parameter int PLANES  = 8,
  parameter int BUS_W   = 16,
  parameter int VIEW_AW = 20,
  parameter int ADDR_W  = 22,
  localparam int NPIX   = H_PIX * V_LINES,
  localparam int SA_W   = $clog2(NPIX),
  localparam int PL_W   = $clog2(PLANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic              ready_o,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [SA_W-1:0]   st_addr_o,
  output logic              st_re_o,
  output logic              st_we_o,
  output logic [PLANES-1:0] st_wdata_o,
  input  logic [PLANES-1:0] st_rdata_i
);
  kind_e             kind;
  logic [PL_W-1:0]   plane;
  logic [SA_W-1:0]   base;
  logic              go;
  logic [PLANES-1:0] mask;
  logic              mask_we;

  fbv_decode #(
    .ADDR_W(ADDR_W), .VIEW_AW(VIEW_AW), .PLANES(PLANES),
    .BUS_W(BUS_W), .NPIX(NPIX), .SA_W(SA_W)
  ) u_dec (
    .addr_i (addr_i),
    .mask_i (mask),
    .kind_o (kind),
    .plane_o(plane),
    .base_o (base),
    .go_o   (go)
  );

  fbv_mask_reg #(.PLANES(PLANES)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_we),
    .wdata_i(wdata_i[PLANES-1:0]),
    .mask_o (mask)
  );

  fbv_seq #(
    .PLANES(PLANES), .BUS_W(BUS_W), .SA_W(SA_W), .PL_W(PL_W)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .kind_i    (kind),
    .plane_i   (plane),
    .base_i    (base),
    .go_i      (go),
    .mask_i    (mask),
    .mask_we_o (mask_we),
    .ready_o   (ready_o),
    .rdata_o   (rdata_o),
    .st_addr_o (st_addr_o),
    .st_re_o   (st_re_o),
    .st_we_o   (st_we_o),
    .st_wdata_o(st_wdata_o),
    .st_rdata_i(st_rdata_i)
  );

  // R8
  store_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_re_o || st_we_o) |-> (32'(st_addr_o) < 32'(NPIX)));
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!ready_o && !st_re_o && !st_we_o));
endmodule

// File: tb/fb_dual_view_test.sv
`timescale 1ns/1ps
module fb_dual_view_test;
  localparam int NPIX = 1152 * 900;

  typedef struct packed {
    logic        we;
    logic [21:0] addr;
    logic [15:0] wd;
    logic [15:0] ex;
    logic [3:0]  rq;
  } vec_t;

  // Hand-derived expectations; each comment names the requirement.
  localparam vec_t VECS [0:21] = '{
    '{1'b1, 22'h100000, 16'h00A5, 16'h0000, 4'd7},   // R7 pixel 0 <- A5
    '{1'b0, 22'h100000, 16'h0000, 16'h00A5, 4'd7},   // R7
    '{1'b1, 22'h000000, 16'h8001, 16'h0000, 4'd4},   // R4 plane0 word0
    '{1'b0, 22'h100000, 16'h0000, 16'h00A5, 4'd4},   // R4 other bits kept
    '{1'b0, 22'h10000F, 16'h0000, 16'h0001, 4'd3},   // R3 bit0 = pixel 15
    '{1'b1, 22'h0E0000, 16'h0000, 16'h0000, 4'd4},   // R4 plane7 cleared
    '{1'b0, 22'h100000, 16'h0000, 16'h0025, 4'd4},   // R4
    '{1'b0, 22'h0A0000, 16'h0000, 16'h8000, 4'd5},   // R5 plane5
    '{1'b0, 22'h000000, 16'h0000, 16'h8001, 4'd5},   // R5 plane0
    '{1'b1, 22'h100011, 16'h00FF, 16'h0000, 4'd7},   // R7 pixel 17
    '{1'b0, 22'h060002, 16'h0000, 16'h4000, 4'd3},   // R3 plane3 word1
    '{1'b1, 22'h1FD1FF, 16'h003C, 16'h0000, 4'd8},   // R8 last pixel
    '{1'b0, 22'h1FD1FF, 16'h0000, 16'h003C, 4'd8},   // R8
    '{1'b0, 22'h05FA3E, 16'h0000, 16'h0001, 4'd3},   // R3 last word plane2
    '{1'b1, 22'h1FD200, 16'h0077, 16'h0000, 4'd8},   // R8 beyond
    '{1'b0, 22'h1FD200, 16'h0000, 16'h0000, 4'd8},   // R8
    '{1'b1, 22'h01FA40, 16'hFFFF, 16'h0000, 4'd8},   // R8 word 64800
    '{1'b0, 22'h01FA40, 16'h0000, 16'h0000, 4'd8},   // R8
    '{1'b0, 22'h200000, 16'h0000, 16'h00FF, 4'd2},   // R2 mask
    '{1'b0, 22'h300000, 16'h0000, 16'h0000, 4'd2},   // R2 unmapped
    '{1'b1, 22'h300000, 16'h1234, 16'h0000, 4'd2},   // R2
    '{1'b0, 22'h200000, 16'h0000, 16'h00FF, 4'd2}    // R2 mask untouched
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [21:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ready;
  logic [15:0] rdata;
  logic [19:0] st_addr;
  logic        st_re, st_we;
  logic [7:0]  st_wdata;
  logic [7:0]  st_rdata = '0;

  int nvec = 0;
  int nfail = 0;
  int acc_cnt = 0;
  int bad_cnt = 0;
  logic [7:0] mem [int];

  always #4 clk = ~clk;

  fb_dual_view uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .st_addr_o(st_addr),
    .st_re_o(st_re), .st_we_o(st_we), .st_wdata_o(st_wdata), .st_rdata_i(st_rdata)
  );

  // Pixel store model: one cycle read latency.
  always @(posedge clk) begin
    if (st_re) begin
      st_rdata <= mem.exists(int'(st_addr)) ? mem[int'(st_addr)] : 8'h00;
      acc_cnt++;
    end
    if (st_we) begin
      mem[int'(st_addr)] = st_wdata;
      acc_cnt++;
    end
    if ((st_re || st_we) && int'(st_addr) >= NPIX) bad_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic w, input logic [21:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output int cyc, output int accs);
    int a0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    a0 = acc_cnt;
    cyc = 0;
    rd = '0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end while (!ready && cyc < 1000);
    rd = rdata;
    req = 1'b0;
    accs = acc_cnt - a0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 ready one cycle", 32'(ready), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int cyc, accs;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(ready), 0);
    chk("R1 st_re", 32'(st_re), 0);
    chk("R1 st_we", 32'(st_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 32'({ready, st_re, st_we}), 0);
    bus_op(1'b0, 22'h200000, 16'h0, rd, cyc, accs);
    chk("R1 mask reset value", 32'(rd), 32'h00FF);
    chk("R9 mask latency", 32'(cyc), 1);

    for (int i = 0; i < 22; i++) begin
      bus_op(VECS[i].we, VECS[i].addr, VECS[i].wd, rd, cyc, accs);
      if (!VECS[i].we) chk($sformatf("R%0d vec %0d", VECS[i].rq, i), 32'(rd), 32'(VECS[i].ex));
    end

    // R9 / R10 latency and store traffic
    bus_op(1'b0, 22'h000000, 16'h0, rd, cyc, accs);
    chk("R9 plane read latency", 32'(cyc), 33);
    chk("R10 plane read accesses", 32'(accs), 16);
    bus_op(1'b1, 22'h000000, 16'h8001, rd, cyc, accs);
    chk("R9 plane write latency", 32'(cyc), 33);
    chk("R10 plane write accesses", 32'(accs), 32);
    bus_op(1'b0, 22'h100000, 16'h0, rd, cyc, accs);
    chk("R9 pixel read latency", 32'(cyc), 3);
    chk("R10 pixel read accesses", 32'(accs), 1);
    bus_op(1'b1, 22'h100000, 16'h0025, rd, cyc, accs);
    chk("R9 pixel write latency", 32'(cyc), 3);
    chk("R10 pixel write accesses", 32'(accs), 2);
    bus_op(1'b1, 22'h1FD200, 16'h0055, rd, cyc, accs);
    chk("R8 no store access", 32'(accs), 0);
    chk("R9 out-of-range latency", 32'(cyc), 1);

    // R6 / R7 with a partial mask
    bus_op(1'b1, 22'h200000, 16'h000F, rd, cyc, accs);
    bus_op(1'b0, 22'h200000, 16'h0, rd, cyc, accs);
    chk("R2 mask readback", 32'(rd), 32'h000F);
    bus_op(1'b0, 22'h0A0000, 16'h0, rd, cyc, accs);
    chk("R6 disabled plane read", 32'(rd), 0);
    chk("R6 disabled read no access", 32'(accs), 0);
    bus_op(1'b1, 22'h0E0000, 16'hFFFF, rd, cyc, accs);
    chk("R6 disabled write no access", 32'(accs), 0);
    bus_op(1'b1, 22'h100000, 16'h00FF, rd, cyc, accs);
    bus_op(1'b0, 22'h100000, 16'h0, rd, cyc, accs);
    chk("R7 masked pixel read", 32'(rd), 32'h000F);
    bus_op(1'b1, 22'h200000, 16'h00FF, rd, cyc, accs);
    bus_op(1'b0, 22'h100000, 16'h0, rd, cyc, accs);
    chk("R7 masked pixel write / R6 plane7 kept", 32'(rd), 32'h002F);

    // R1 reset restores mask
    bus_op(1'b1, 22'h200000, 16'h0003, rd, cyc, accs);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bus_op(1'b0, 22'h200000, 16'h0, rd, cyc, accs);
    chk("R1 mask after second reset", 32'(rd), 32'h00FF);

    chk("R8 store never out of range", 32'(bad_cnt), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule